// File: doc/BRIEF.md
# Nibble-Serial Register Write Link

This block moves register writes from a processor core into a pin cell over a path only four bits wide. A sender takes a request consisting of a target select and a 32-bit word. It turns the request into a stream of nibbles on the link, one nibble per clock. A receiver at the far end decodes the stream and loads the word into one of three target registers: mode, X or Y. A select with no target produces a bare acknowledge strobe instead.

A write costs ten link cycles: a command nibble, eight payload nibbles with the least significant nibble first, and one idle nibble. An acknowledge costs two link cycles: its command nibble and the idle nibble. The lowest bit of the command nibble tells the receiver whether a payload follows. The receiver therefore knows the length of every transfer from its first nibble, and it never has to search for framing inside the payload.

Top module: `nib_link`

## Requirements
- R1: While rst_ni is low and after its release, link_o is 4'h0, busy_o is 0, ack_o is 0, and mode_o, x_o and y_o are all zero.
- R2: A request accepted at a clock edge puts its command nibble on link_o in the following cycle. The select codes and their command nibbles are: sel_i 0 (acknowledge) gives 4'b0001, sel_i 1 (mode) gives 4'b0010, sel_i 2 (X) gives 4'b0100, and sel_i 3 (Y) gives 4'b0110.
- R3: The command nibble of a write is followed by the eight nibbles of data_i, least significant nibble first, and then by the idle nibble 4'h0. The whole write occupies 10 cycles.
- R4: An acknowledge puts 4'b0001 on link_o for one cycle and then 4'h0, with no payload, for 2 cycles in total.
- R5: busy_o is 1 exactly while a command or payload nibble is on link_o, and it is 0 in the idle cycle. A request seen while busy_o is 0 is accepted.
- R6: A request seen while busy_o is 1 is ignored. The nibble stream in progress continues unchanged, and no extra acknowledge or register write results.
- R7: After the eighth payload nibble, the selected register takes the full 32-bit word in the next cycle, which is the idle cycle of that write. The other two registers keep their values.
- R8: ack_o is 1 for exactly one cycle, the cycle after the command nibble 4'b0001 appears on the link. No register changes as a result.
- R9: No target register changes while busy_o is 1, so a transfer that is under way leaves the registers as they were.
- R10: While a payload is being received, every nibble is taken as data, including values equal to a command nibble.
- R11: A request made during the idle cycle of a write is accepted. Its command nibble follows that idle nibble at once, so consecutive writes are 10 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request |
| sel_i | input | 2 | Target: 0 acknowledge, 1 mode, 2 X, 3 Y |
| data_i | input | 32 | Word to write, sampled when the request is accepted |
| busy_o | output | 1 | Sender is putting a command or payload nibble on the link |
| link_o | output | 4 | Nibble currently on the link |
| ack_o | output | 1 | One-cycle acknowledge strobe |
| mode_o | output | 32 | Mode register |
| x_o | output | 32 | X register |
| y_o | output | 32 | Y register |

## Verification
Two functions coincide in the idle cycle of a write. In that cycle the receiver commits the word to its register, and the sender is free to accept the next request. The bench issues requests back to back, so every new request is raised exactly in the idle cycle of the write before it. It then checks two things together. The committed register must appear in that cycle and match the queued expectation. The next command nibble must follow on the very next cycle with no gap. A second overlap is a request raised while a payload is in flight. That request must leave the stream and the registers untouched, and this is judged by the nibble sequence and by the scoreboard queue ending empty.

// File: rtl/nib_link_pkg.sv
package nib_link_pkg;
  localparam int unsigned LINK_W = 4;
  localparam int unsigned NREG   = 3;

  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_X    = 2'd2,
    SEL_Y    = 2'd3
  } sel_e;

  // bit0 set: acknowledge only; bits[2:1]: target for a payload write
  function automatic logic [LINK_W-1:0] cmd_nib(sel_e s);
    return {1'b0, s, (s == SEL_ACK)};
  endfunction
endpackage

// File: rtl/nl_tx.sv
module nl_tx
  import nib_link_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [LINK_W-1:0] nib_o
);
  localparam int unsigned NIBS  = DATA_W / LINK_W;
  localparam int unsigned CNT_W = $clog2(NIBS + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              act_q;
  logic [LINK_W-1:0] nib_q;
  logic              accept;

  assign accept = req_i & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      act_q  <= 1'b0;
      nib_q  <= '0;
    end else if (accept) begin
      nib_q  <= cmd_nib(sel_i);
      act_q  <= 1'b1;
      sh_q   <= data_i;
      left_q <= (sel_i == SEL_ACK) ? '0 : CNT_W'(NIBS);
    end else if (left_q != '0) begin
      nib_q  <= sh_q[LINK_W-1:0];
      sh_q   <= sh_q >> LINK_W;
      left_q <= left_q - 1'b1;
      act_q  <= 1'b1;
    end else begin
      nib_q  <= '0;
      act_q  <= 1'b0;
    end
  end

  assign busy_o = act_q;
  assign nib_o  = nib_q;
endmodule

// File: rtl/nl_rx.sv
module nl_rx
  import nib_link_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINK_W-1:0] nib_i,
  output logic              ack_o,
  output logic              wr_o,
  output sel_e              wr_sel_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned NIBS  = DATA_W / LINK_W;
  localparam int unsigned CNT_W = $clog2(NIBS + 1);

  logic [CNT_W-1:0]  cnt_q;
  sel_e              tgt_q;
  logic [DATA_W-1:0] acc_q;
  logic              ack_q;
  logic [DATA_W-1:0] acc_nxt;

  assign acc_nxt = {nib_i, acc_q[DATA_W-1:LINK_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgt_q <= SEL_ACK;
      acc_q <= '0;
      ack_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (cnt_q == '0) begin
        if (nib_i[0]) begin
          ack_q <= 1'b1;
        end else if (nib_i[2:1] != 2'b00) begin
          tgt_q <= sel_e'(nib_i[2:1]);
          cnt_q <= CNT_W'(NIBS);
        end
      end else begin
        // payload: any value is data
        acc_q <= acc_nxt;
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ack_o     = ack_q;
  assign wr_o      = (cnt_q == CNT_W'(1));
  assign wr_sel_o  = tgt_q;
  assign wr_data_o = acc_nxt;
endmodule

// File: rtl/nl_regbank.sv
module nl_regbank
  import nib_link_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  sel_e              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && (wr_sel_i == sel_e'(i + 1))) q <= wr_data_i;
    end
    assign regs_o[i] = q;
  end
endmodule

// File: rtl/nib_link.sv
module nib_link
  import nib_link_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic [LINK_W-1:0] link_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] y_o
);
  logic [LINK_W-1:0]           link;
  logic                        wr;
  sel_e                        wr_sel;
  logic [DATA_W-1:0]           wr_data;
  logic [NREG-1:0][DATA_W-1:0] regs;

  nl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .sel_i  (sel_e'(sel_i)),
    .data_i (data_i),
    .busy_o (busy_o),
    .nib_o  (link)
  );

  nl_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nib_i     (link),
    .ack_o     (ack_o),
    .wr_o      (wr),
    .wr_sel_o  (wr_sel),
    .wr_data_o (wr_data)
  );

  nl_regbank #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  assign link_o = link;
  assign mode_o = regs[0];
  assign x_o    = regs[1];
  assign y_o    = regs[2];
endmodule

// File: rtl/nib_link_chk.sv
module nib_link_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [1:0]        sel_i,
  input logic              busy_o,
  input logic [3:0]        link_o,
  input logic              ack_o,
  input logic [DATA_W-1:0] mode_o,
  input logic [DATA_W-1:0] x_o,
  input logic [DATA_W-1:0] y_o
);
  a_r2_cmd_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && sel_i != 2'd0) |=> (link_o == {1'b0, $past(sel_i), 1'b0}));

  a_r4_ack_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && sel_i == 2'd0) |=> (link_o == 4'b0001));

  a_r5_idle_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (link_o == 4'h0));

  a_r8_ack_after_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(link_o) == 4'b0001 && $past(busy_o)));

  a_r8_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r9_regs_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(mode_o) && $stable(x_o) && $stable(y_o)));
endmodule

bind nib_link nib_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .sel_i  (sel_i),
  .busy_o (busy_o),
  .link_o (link_o),
  .ack_o  (ack_o),
  .mode_o (mode_o),
  .x_o    (x_o),
  .y_o    (y_o)
);

// File: tb/tb_nib_link.sv
module tb_nib_link;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic [31:0] data = '0;
  logic        busy, ack;
  logic [3:0]  link;
  logic [31:0] mode_r, x_r, y_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [1:0] sel; logic [31:0] data; } item_t;
  item_t exp_q[$];
  logic [31:0] model [1:3];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nib_link dut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .sel_i (sel), .data_i (data),
    .busy_o (busy), .link_o (link), .ack_o (ack),
    .mode_o (mode_r), .x_o (x_r), .y_o (y_r)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(logic [1:0] s);
    return (s == 2'd1) ? mode_r : (s == 2'd2) ? x_r : y_r;
  endfunction

  // called at a negedge; returns at the negedge of the idle cycle
  task automatic send(logic [1:0] s, logic [31:0] d, bit inject);
    logic [3:0] cmd;
    item_t it;
    cmd = {1'b0, s, (s == 2'd0)};
    it.sel = s; it.data = d;
    exp_q.push_back(it);
    req = 1'b1; sel = s; data = d;
    @(negedge clk);
    req = 1'b0; data = '0;
    chk(link == cmd, "R2 command nibble", 32'(link), 32'(cmd));
    chk(busy == 1'b1, "R5 busy on command", 32'(busy), 32'd1);
    if (s != 2'd0) begin
      for (int n = 0; n < 8; n++) begin
        if (inject && n == 3) begin
          req = 1'b1; sel = 2'd0;
        end
        @(negedge clk);
        req = 1'b0;
        chk(link == d[4*n +: 4], "R3 payload nibble", 32'(link), 32'(d[4*n +: 4]));
        chk(busy == 1'b1, "R5 busy on payload", 32'(busy), 32'd1);
        if (n == 7)
          chk(reg_of(s) == model[s], "R9 target held mid transfer", reg_of(s), model[s]);
      end
      @(negedge clk);
      model[s] = d;
      chk(reg_of(s) == d, "R7 register in idle cycle", reg_of(s), d);
    end else begin
      @(negedge clk);
    end
    chk(link == 4'h0, "R3 R4 idle nibble", 32'(link), 32'h0);
    chk(busy == 1'b0, "R5 busy low in idle", 32'(busy), 32'd0);
  endtask

  task automatic event_seen(logic [1:0] s, logic [31:0] d, string tag);
    item_t it;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " unexpected event"}, d, 32'hx);
    end else begin
      it = exp_q.pop_front();
      chk(it.sel == s, {tag, " event kind"}, 32'(s), 32'(it.sel));
      if (s != 2'd0) chk(it.data == d, {tag, " event value"}, d, it.data);
    end
  endtask

  // monitor
  initial begin
    logic [31:0] pm, px, py;
    logic pa;
    pm = '0; px = '0; py = '0; pa = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (ack) begin
          event_seen(2'd0, 32'h0, "R8 ack");
          chk(pa == 1'b0, "R8 ack single cycle", 32'(pa), 32'd0);
        end
        if (mode_r != pm) event_seen(2'd1, mode_r, "R7 mode");
        if (x_r != px)    event_seen(2'd2, x_r, "R7 x R10");
        if (y_r != py)    event_seen(2'd3, y_r, "R7 y");
        pm = mode_r; px = x_r; py = y_r; pa = ack;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model[1] = '0; model[2] = '0; model[3] = '0;
    repeat (3) @(negedge clk);
    chk(link == 4'h0 && busy == 1'b0 && ack == 1'b0, "R1 in reset", {link, busy, ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode_r == 0 && x_r == 0 && y_r == 0, "R1 regs after reset", mode_r | x_r | y_r, 32'h0);
    chk(link == 4'h0 && busy == 1'b0, "R1 idle after reset", 32'(link), 32'h0);

    send(2'd1, 32'h7654_3210, 1'b0);          // R2 R3 R7 mode
    @(negedge clk);
    send(2'd0, 32'h0, 1'b0);                  // R4 R8 ack
    chk(mode_r == model[1], "R8 regs unchanged by ack", mode_r, model[1]);
    send(2'd2, 32'h1111_4621, 1'b0);          // R10 command-like payload, R11 back to back
    send(2'd3, 32'hFFFF_FFFF, 1'b1);          // R6 request while busy, R11
    send(2'd1, 32'h0BAD_F00D, 1'b0);          // R11
    chk(x_r == model[2] && y_r == model[3], "R7 other registers kept", x_r ^ y_r, model[2] ^ model[3]);
    send(2'd0, 32'h0, 1'b0);
    send(2'd2, 32'h8000_0001, 1'b0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 no extra or missing events", 32'(exp_q.size()), 32'd0);
    chk(link == 4'h0 && busy == 1'b0, "R5 link idle at end", 32'(link), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule